// File: doc/BRIEF.md
# Routed Interrupt Controller

The block gathers up to 32 level-sensitive interrupt sources from peripherals and presents them to a processor as six interrupt lines, numbered 2 to 7. Every source is captured in a pending register, gated by an enable mask, and steered by a programmable routing table onto exactly one CPU line or onto none. Several sources may share a line. Software finds which sources are active on a shared line by reading the mask and the pending register and ANDing them.

Software reaches the block through a simple register port. A write happens on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from the addressed register. Address 0 holds the enable mask. Address 1 holds the pending register, which is cleared by writing ones. Addresses 2 to 5 hold the four routing words. Enabling or disabling one source is a read-modify-write of the mask that software performs. The block adds no priority, vectoring or nesting: each CPU line is a plain OR.

Top module: `route_irq_ctrl`

## Requirements
- R1: After reset, the mask reads 32'h0000_1100, which enables only source 8 and source 12. The pending register reads 0 and `cpu_irq_o` is 0.
- R2: A write to address 0 loads all 32 mask bits. Bit n enables source n, and reading address 0 returns the mask.
- R3: Pending bit n is set on every clock edge at which `src_i[n]` is high, whatever the mask holds. It stays set until it is cleared. Reading address 1 returns the pending register.
- R4: A write to address 1 clears pending bit n on that edge if bit n of the write data is 1 and `src_i[n]` is low in that cycle. Zero bits in the write data have no effect.
- R5: Routing word r sits at address 2+r. Source n uses word n/8, bits 4*(n%8)+3 down to 4*(n%8). A field value k from 2 to 7 routes the source to line k. Any other value (0, 1, 8 to 15) leaves the source unrouted.
- R6: The routing after reset is as follows: source 8 to line 7, source 15 to line 6, source 14 to line 5, source 10 to line 4, source 12 to line 3, and sources 0-4, 9, 13 and 16-21 to line 2. Every other source is unrouted. The routing words read 32'h0002_2222, 32'h6523_0427, 32'h0022_2222 and 0.
- R7: `cpu_irq_o[k-2]` is the OR over all sources that are masked in, pending, and routed to line k. It is combinational from the registered state, so a rising source shows up after one clock edge. Several sources can drive the same line.
- R8: A line stays asserted while an enabled source routed to it is held high, even when software writes a clear for that source.
- R9: Addresses 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| src_i | input | 32 | Level interrupt sources, bit n is source n |
| cpu_irq_o | output | 6 | CPU lines, bit j is line j+2 |

## Verification
Register writes and source levels take effect at the first rising edge after they are applied. Pending bits, the mask, the routing and `cpu_irq_o` therefore all change one edge after the stimulus, and read data follows the address in the same cycle. The bench drives inputs just after the falling edge. A behavioural model updates at each rising edge, and the bench compares `cpu_irq_o` and `bus_rdata` against that model at every falling edge. All results are due there, half a period after the edge that produced them. Directed checks read registers and lines in that same falling-edge slot, and they cover reset values, default routing, sharing, unrouted codes, and a clear that loses against a held source.

// File: rtl/ric_pkg.sv
package ric_pkg;
  localparam int NSRC      = 32;
  localparam int NLINE     = 6;
  localparam int LINE_BASE = 2;
  localparam int RW        = 4;
  localparam int DW        = 32;
  localparam int AW        = 3;
  localparam int PER_WORD  = DW / RW;
  localparam int NROUTE    = NSRC / PER_WORD;
  localparam logic [DW-1:0] RESET_MASK = 32'h0000_1100;

  localparam logic [AW-1:0] ADDR_MASK  = 3'd0;
  localparam logic [AW-1:0] ADDR_STAT  = 3'd1;
  localparam int            ADDR_ROUTE = 2;

  function automatic logic [RW-1:0] dflt_line(int n);
    case (n)
      8:  dflt_line = RW'(7);
      15: dflt_line = RW'(6);
      14: dflt_line = RW'(5);
      10: dflt_line = RW'(4);
      12: dflt_line = RW'(3);
      0, 1, 2, 3, 4, 9, 13, 16, 17, 18, 19, 20, 21: dflt_line = RW'(2);
      default: dflt_line = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] dflt_word(int r);
    logic [DW-1:0] w;
    w = '0;
    for (int f = 0; f < PER_WORD; f++) begin
      w[f*RW +: RW] = dflt_line(r * PER_WORD + f);
    end
    return w;
  endfunction
endpackage

// File: rtl/ric_regs.sv
module ric_regs
  import ric_pkg::*;
#(
  parameter int NS   = NSRC,
  parameter int W    = DW,
  parameter int A    = AW,
  parameter int NR   = NROUTE,
  parameter logic [W-1:0] MASK_INIT = RESET_MASK
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [A-1:0]    bus_addr,
  input  logic [W-1:0]    bus_wdata,
  input  logic [NS-1:0]   pend_q,
  output logic [W-1:0]    bus_rdata,
  output logic [NS-1:0]   mask_q,
  output logic [NS-1:0]   stat_clr,
  output logic [NR*W-1:0] route_flat
);
  logic [NR-1:0][W-1:0] route_q;
  logic                 wr;

  assign wr = bus_en && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_INIT[NS-1:0];
    end else if (wr && bus_addr == ADDR_MASK) begin
      mask_q <= bus_wdata[NS-1:0];
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_q[r] <= dflt_word(r);
      end else if (wr && bus_addr == A'(ADDR_ROUTE + r)) begin
        route_q[r] <= bus_wdata;
      end
    end
    assign route_flat[r*W +: W] = route_q[r];
  end

  assign stat_clr = (wr && bus_addr == ADDR_STAT) ? bus_wdata[NS-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_MASK) bus_rdata = W'(mask_q);
    if (bus_addr == ADDR_STAT) bus_rdata = W'(pend_q);
    for (int r = 0; r < NR; r++) begin
      if (bus_addr == A'(ADDR_ROUTE + r)) bus_rdata = route_q[r];
    end
  end
endmodule

// File: rtl/ric_status.sv
module ric_status #(
  parameter int NS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src_i,
  input  logic [NS-1:0] stat_clr,
  output logic [NS-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= src_i | (pend_q & ~stat_clr);
  end
endmodule

// File: rtl/ric_router.sv
module ric_router #(
  parameter int NS    = 32,
  parameter int NL    = 6,
  parameter int BASE  = 2,
  parameter int FW    = 4
) (
  input  logic [NS-1:0]    active,
  input  logic [NS*FW-1:0] route_flat,
  output logic [NL-1:0]    irq
);
  for (genvar j = 0; j < NL; j++) begin : g_line
    logic [NS-1:0] hit;
    for (genvar i = 0; i < NS; i++) begin : g_src
      assign hit[i] = active[i] && (route_flat[i*FW +: FW] == FW'(j + BASE));
    end
    assign irq[j] = |hit;
  end
endmodule

// File: rtl/route_irq_ctrl.sv
module route_irq_ctrl
  import ric_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int NL = NLINE,
  parameter int W  = DW,
  parameter int A  = AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [A-1:0]  bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [NS-1:0] src_i,
  output logic [NL-1:0] cpu_irq_o
);
  localparam int PW = W / RW;
  localparam int NR = NS / PW;

  logic [NS-1:0]   mask_q;
  logic [NS-1:0]   pend_q;
  logic [NS-1:0]   stat_clr;
  logic [NR*W-1:0] route_flat;
  logic [NS-1:0]   active;

  ric_regs #(.NS(NS), .W(W), .A(A), .NR(NR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
    .bus_rdata(bus_rdata), .mask_q(mask_q), .stat_clr(stat_clr),
    .route_flat(route_flat)
  );

  ric_status #(.NS(NS)) u_status (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .stat_clr(stat_clr),
    .pend_q(pend_q)
  );

  assign active = mask_q & pend_q;

  ric_router #(.NS(NS), .NL(NL), .BASE(LINE_BASE), .FW(RW)) u_router (
    .active(active), .route_flat(route_flat[NS*RW-1:0]), .irq(cpu_irq_o)
  );
endmodule

// File: rtl/ric_checker.sv
module ric_checker #(
  parameter int NS = 32,
  parameter int NL = 6,
  parameter int W  = 32,
  parameter int A  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [A-1:0]  bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [NS-1:0] src_i,
  input logic [NL-1:0] cpu_irq_o,
  input logic [NS-1:0] mask_q,
  input logic [NS-1:0] pend_q
);
  logic past_ok;
  logic wr_mask, wr_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign wr_mask = bus_en && bus_we && bus_addr == A'(0);
  assign wr_stat = bus_en && bus_we && bus_addr == A'(1);

  // R3: a high source is pending after the next edge
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(src_i) & ~pend_q) == '0));

  // R4: a pending bit only drops after a one-write to it
  p_clear_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(pend_q) & ~pend_q &
                  ~($past(wr_stat) ? $past(bus_wdata[NS-1:0]) : '0)) == '0));

  // R2: the mask moves only on a mask write
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(wr_mask)) |-> $stable(mask_q));

  // R7: an asserted line needs an enabled pending source
  p_line_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq_o != '0) |-> ((mask_q & pend_q) != '0));

  // R8: an enabled held source keeps some line busy or is unrouted; at least stays pending
  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(src_i) != '0) |-> ((pend_q & $past(src_i)) == $past(src_i)));
endmodule

bind route_irq_ctrl ric_checker #(.NS(NS), .NL(NL), .W(W), .A(A)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_i(src_i),
  .cpu_irq_o(cpu_irq_o), .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/tb_route_irq_ctrl.sv
`timescale 1ns/1ps
module tb_route_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_i = '0;
  logic [5:0]  cpu_irq_o;

  int checks = 0, fails = 0;
  logic started = 1'b0;

  always #2 clk = ~clk;

  route_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src_i), .cpu_irq_o(cpu_irq_o)
  );

  // behavioural reference
  logic [31:0] m_mask, m_pend;
  int          m_rt[32];

  function automatic int def_ln(int n);
    case (n)
      8: return 7; 15: return 6; 14: return 5; 10: return 4; 12: return 3;
      0, 1, 2, 3, 4, 9, 13, 16, 17, 18, 19, 20, 21: return 2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 32'h0000_1100;
      m_pend = '0;
      for (int n = 0; n < 32; n++) m_rt[n] = def_ln(n);
    end else begin
      logic [31:0] clr;
      clr = (bus_en && bus_we && bus_addr == 3'd1) ? bus_wdata : '0;
      m_pend = src_i | (m_pend & ~clr);
      if (bus_en && bus_we && bus_addr == 3'd0) m_mask = bus_wdata;
      if (bus_en && bus_we && bus_addr >= 3'd2 && bus_addr <= 3'd5)
        for (int f = 0; f < 8; f++)
          m_rt[(int'(bus_addr) - 2) * 8 + f] = int'((bus_wdata >> (4 * f)) & 32'hF);
    end
  end

  function automatic logic [5:0] exp_irq();
    logic [5:0] v = '0;
    for (int k = 0; k < 6; k++)
      for (int n = 0; n < 32; n++)
        if (m_mask[n] && m_pend[n] && m_rt[n] == k + 2) v[k] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    logic [31:0] v = '0;
    if (a == 3'd0) v = m_mask;
    else if (a == 3'd1) v = m_pend;
    else if (a <= 3'd5)
      for (int f = 0; f < 8; f++) v |= 32'(m_rt[(int'(a) - 2) * 8 + f] & 15) << (4 * f);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, half a period after each edge
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("R7 lines", 32'(cpu_irq_o), 32'(exp_irq()));
      case (bus_addr)
        3'd0: chk("R2 mask read", bus_rdata, exp_rd(bus_addr));
        3'd1: chk("R3 status read", bus_rdata, exp_rd(bus_addr));
        3'd6, 3'd7: chk("R9 spare read", bus_rdata, 32'h0);
        default: chk("R5 route read", bus_rdata, exp_rd(bus_addr));
      endcase
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    #1 bus_en = 0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) step();
    @(negedge clk);
    chk("R1 lines in reset", 32'(cpu_irq_o), 32'h0);
    #1 rst_n = 1;
    step();
    started = 1;
    rd(3'd0, 32'h0000_1100, "R1 reset mask");
    rd(3'd1, 32'h0, "R1 reset status");
    rd(3'd2, 32'h0002_2222, "R6 route word 0");
    rd(3'd3, 32'h6523_0427, "R6 route word 1");
    rd(3'd4, 32'h0022_2222, "R6 route word 2");
    rd(3'd5, 32'h0, "R6 route word 3");

    // timer-like source 8 to line 7
    src_i = 32'h0000_0100; step();
    @(negedge clk); chk("R7 src8 on line 7", 32'(cpu_irq_o), 32'h20); #1;
    // masked-out source 0 is captured but raises nothing
    src_i = 32'h0000_0001; step();
    @(negedge clk); chk("R3 masked source no line 2", 32'(cpu_irq_o[0]), 32'h0); #1;
    rd(3'd1, 32'h0000_0101, "R3 status captures masked source");
    // clear with sources low
    wr(3'd1, 32'h0000_0101);
    rd(3'd1, 32'h0000_0001, "R4 cleared except held src0");
    src_i = 32'h0; wr(3'd1, 32'h0000_0001);
    rd(3'd1, 32'h0, "R4 cleared after source drop");
    // held source beats the clear
    src_i = 32'h0000_1000; step();
    wr(3'd1, 32'h0000_1000);
    @(negedge clk); chk("R8 line 3 held through clear", 32'(cpu_irq_o), 32'h02); #1;
    src_i = 32'h0; wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk); chk("R4 line drops after clear", 32'(cpu_irq_o), 32'h0); #1;
    // sharing: src0 enabled and rerouted to line 7 alongside src8
    wr(3'd0, 32'h0000_1101);
    wr(3'd2, 32'h0002_2227);
    src_i = 32'h0000_0001; step(); src_i = 32'h0;
    @(negedge clk); chk("R7 src0 shares line 7", 32'(cpu_irq_o), 32'h20); #1;
    // unrouted codes 1 and 9
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0002_2221);
    src_i = 32'h0000_0001; step(); src_i = 32'h0;
    @(negedge clk); chk("R5 code 1 unrouted", 32'(cpu_irq_o), 32'h0); #1;
    wr(3'd2, 32'h0002_2229); step();
    @(negedge clk); chk("R5 code 9 unrouted", 32'(cpu_irq_o), 32'h0); #1;
    // spare addresses
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, 32'h0, "R9 spare reads zero");
    rd(3'd0, 32'h0000_1101, "R9 mask untouched by spare write");
    // mask disable leaves pending but drops line
    wr(3'd1, 32'hFFFF_FFFF);
    src_i = 32'h0000_0100; step(); src_i = 32'h0;
    wr(3'd0, 32'h0);
    @(negedge clk); chk("R2 mask off drops line", 32'(cpu_irq_o), 32'h0); #1;
    rd(3'd1, 32'h0000_0100, "R2 pending kept while masked");

    // mixed traffic, compared every cycle by the model
    lf = 32'hACE1_1234;
    for (int c = 0; c < 600; c++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      src_i = lf & {lf[15:0], lf[31:16]} & 32'h003F_FFFF;
      bus_en = lf[3] | lf[9];
      bus_we = lf[5] & lf[3];
      bus_addr = lf[12:10];
      bus_wdata = {lf[7:0], lf[31:8]};
      step();
    end
    bus_en = 0; bus_we = 0; src_i = '0;
    repeat (4) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule